// File: doc/BRIEF.md
# Bus Memory Presence Snoop Responder

This block is a target on an 8-bit memory bus. It keeps its own copy of every byte written to the region below address 0xA0000, and on reads it decides per 64 KB page whether to answer. Some of that range may already be served by RAM on the host board. The block learns which pages have host RAM and which do not, without any base address being set. To do this, the first read of a page is stretched by holding the ready line low. While the cycle is stretched the block only watches the bus. When the stretch ends, it compares the byte the host left on the data lines with its own stored byte.

A match means the host answered the read. That page is then marked host-backed and the block stays silent on it. A mismatch means nobody answered. The page is then marked as served, and the block drives its stored byte at once, for this read and for every later read of that page, with no wait states. Reset returns every page to the unlearned state. The internal storage is a synchronous RAM indexed by page and a parameterised number of low offset bits. With the offset width set to 16, it holds the full 640 KB image.

Top module: `pg_snoop_responder`

## Requirements
- R1: Reads and writes at addresses 0xA0000 and above are ignored: ready_pull stays 0 and data_oe_n stays 1.
- R2: After an active-high synchronous reset, ready_pull is 0, data_oe_n is 1 and all 16 pages (page = address bits [19:16]) are unlearned, whatever they had learned before.
- R3: The first read of an unlearned page holds ready_pull at 1 for exactly HOLD_CYC cycles, where HOLD_CYC = ceil(HOLD_NS * CLK_MHZ / 1000), which is 80 by default. data_oe_n stays 1 throughout that time.
- R4: If the byte on bus_data_in after the hold equals the stored byte, the page becomes host-backed. Later reads of a host-backed page never assert ready_pull and never drive data_oe_n low.
- R5: If the byte differs, the page becomes served, and data_oe_n goes low one cycle after ready_pull falls, with the stored byte on bus_data_out.
- R6: A read of a served page drives data_oe_n low 4 clock edges after mem_rd_n falls, with no wait states: two synchroniser stages, one decode edge and one output register edge.
- R7: Every write below 0xA0000 updates the stored byte, whatever the page state.
- R8: data_oe_n is 1 whenever mem_rd_n is 1, so the driver turns off as soon as the read strobe ends.
- R9: After a cycle has been handled, no new cycle starts until both mem_rd_n and mem_wr_n have been seen high.
- R10: Each page learns on its own: learning one page leaves the state of every other page unchanged.
- R11: Once a page is learned, its state does not change until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 20 | Bus address |
| bus_data_in | input | 8 | Data lines as seen on the bus |
| mem_rd_n | input | 1 | Memory read strobe, active low |
| mem_wr_n | input | 1 | Memory write strobe, active low |
| bus_data_out | output | 8 | Byte to drive when data_oe_n is low |
| data_oe_n | output | 1 | Data driver enable, active low |
| ready_pull | output | 1 | 1 holds the bus ready line low (wait state) |

## Verification
The strobe falls at a falling clock edge, and each result is due a fixed number of rising edges later. For a served page, the driver enable is due on the fourth edge. On a first read, ready_pull rises on the fourth edge and is held for exactly HOLD_CYC edges. On a mismatch, the driver enable comes one edge after the hold ends. The bench counts falling edges from the moment it lowers the strobe and compares those counts exactly, not within a window. It checks the driver release 1 ns after raising the strobe.

// File: rtl/pg_snoop_pkg.sv
package pg_snoop_pkg;

    localparam int ADDR_W   = 20;
    localparam int DATA_W   = 8;
    localparam int PAGE_W   = 4;
    localparam int N_PAGES  = 1 << PAGE_W;
    localparam logic [ADDR_W-1:0] CONV_TOP = 20'hA0000;

    typedef enum logic [1:0] {
        PG_UNKNOWN = 2'd0,
        PG_HOST    = 2'd1,
        PG_SERVE   = 2'd2
    } page_st_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_STALL,
        ST_SNOOP,
        ST_DRIVE,
        ST_DRAIN
    } ctl_st_e;

    typedef struct packed {
        logic                 en;
        logic [PAGE_W-1:0]    page;
        page_st_e             state;
    } pg_upd_t;

    function automatic logic is_conv(input logic [ADDR_W-1:0] a);
        return a < CONV_TOP;
    endfunction

    function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: PAGE_W];
    endfunction

    function automatic int hold_cycles(input int clk_mhz, input int hold_ns);
        return (hold_ns * clk_mhz + 999) / 1000;
    endfunction

endpackage

// File: rtl/pg_strobe_sync.sv
module pg_strobe_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '1;
        end else begin
            chain[0] <= d_async;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/pg_store_ram.sv
module pg_store_ram
    import pg_snoop_pkg::*;
#(
    parameter int OFS_W = 6
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int IDX_W = PAGE_W + OFS_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  idx;

    assign idx = {page_of(addr), addr[OFS_W-1:0]};

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
        rdata <= mem[idx];
    end
endmodule

// File: rtl/pg_state_table.sv
module pg_state_table
    import pg_snoop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PAGE_W-1:0] rd_page,
    output page_st_e          rd_state,
    input  pg_upd_t           upd
);
    page_st_e tbl [N_PAGES];

    for (genvar g = 0; g < N_PAGES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                tbl[g] <= PG_UNKNOWN;
            else if (upd.en && upd.page == PAGE_W'(g))
                tbl[g] <= upd.state;
        end

        assert_learned_sticky_R11: assert property (@(posedge clk) disable iff (rst)
            ($past(tbl[g]) != PG_UNKNOWN) |-> (tbl[g] == $past(tbl[g])));

        assert_legal_code_R4: assert property (@(posedge clk) disable iff (rst)
            (tbl[g] != 2'd3));
    end

    assign rd_state = tbl[rd_page];
endmodule

// File: rtl/pg_snoop_ctl.sv
module pg_snoop_ctl
    import pg_snoop_pkg::*;
#(
    parameter int HOLD_CYC = 80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_s_n,
    input  logic              wr_s_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data_in,
    input  logic [DATA_W-1:0] stored,
    input  page_st_e          pg_state,
    output logic [PAGE_W-1:0] pg_sel,
    output pg_upd_t           upd,
    output logic              ram_we,
    output logic              oe_q,
    output logic              ready_q
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);
    localparam int RL_W  = $clog2(HOLD_CYC + 2);

    ctl_st_e            st;
    logic [CNT_W-1:0]   cnt;
    logic [PAGE_W-1:0]  page_q;
    logic               conv;
    logic               strobes_idle;
    logic               start_rd;
    logic               start_wr;

    assign conv         = is_conv(bus_addr);
    assign strobes_idle = rd_s_n && wr_s_n;
    assign start_rd     = (st == ST_IDLE) && !rd_s_n && conv;
    assign start_wr     = (st == ST_IDLE) && rd_s_n && !wr_s_n && conv;
    assign ram_we       = start_wr;
    assign pg_sel       = (st == ST_IDLE) ? page_of(bus_addr) : page_q;

    always_comb begin
        upd       = '0;
        upd.page  = page_q;
        upd.state = PG_UNKNOWN;
        if (st == ST_SNOOP) begin
            upd.en    = 1'b1;
            upd.state = (bus_data_in == stored) ? PG_HOST : PG_SERVE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            page_q  <= '0;
            oe_q    <= 1'b0;
            ready_q <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start_rd) begin
                        page_q <= page_of(bus_addr);
                        st     <= ST_DECIDE;
                    end else if (!strobes_idle) begin
                        st <= ST_DRAIN;
                    end
                end
                ST_DECIDE: begin
                    case (pg_state)
                        PG_SERVE: begin
                            oe_q <= 1'b1;
                            st   <= ST_DRIVE;
                        end
                        PG_HOST: st <= ST_DRAIN;
                        default: begin
                            ready_q <= 1'b1;
                            cnt     <= CNT_W'(HOLD_CYC - 1);
                            st      <= ST_STALL;
                        end
                    endcase
                end
                ST_STALL: begin
                    if (cnt == '0) begin
                        ready_q <= 1'b0;
                        st      <= ST_SNOOP;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_SNOOP: begin
                    if (bus_data_in == stored) begin
                        st <= ST_DRAIN;
                    end else begin
                        oe_q <= 1'b1;
                        st   <= ST_DRIVE;
                    end
                end
                ST_DRIVE: begin
                    if (strobes_idle) begin
                        oe_q <= 1'b0;
                        st   <= ST_IDLE;
                    end
                end
                ST_DRAIN: begin
                    if (strobes_idle) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Length of each ready hold, used only by the checks below.
    logic [RL_W-1:0] run_len;
    always_ff @(posedge clk) begin
        if (rst)          run_len <= '0;
        else if (ready_q) run_len <= run_len + 1'b1;
        else              run_len <= '0;
    end

    assert_hold_length_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(ready_q) |-> (run_len == RL_W'(HOLD_CYC)));

    assert_hold_bounded_R3: assert property (@(posedge clk) disable iff (rst)
        ready_q |-> (run_len < RL_W'(HOLD_CYC)));

    assert_no_drive_in_hold_R3: assert property (@(posedge clk) disable iff (rst)
        ready_q |-> !oe_q);

    assert_host_page_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_DECIDE && $past(pg_state) == PG_HOST) |-> (!oe_q && !ready_q));

    assert_wait_strobes_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_DRAIN && !$past(strobes_idle)) |-> (st == ST_DRAIN));
endmodule

// File: rtl/pg_snoop_responder.sv
module pg_snoop_responder
    import pg_snoop_pkg::*;
#(
    parameter int CLK_MHZ = 100,
    parameter int HOLD_NS = 800,
    parameter int OFS_W   = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [19:0]       bus_addr,
    input  logic [7:0]        bus_data_in,
    input  logic              mem_rd_n,
    input  logic              mem_wr_n,
    output logic [7:0]        bus_data_out,
    output logic              data_oe_n,
    output logic              ready_pull
);
    localparam int HOLD_CYC = hold_cycles(CLK_MHZ, HOLD_NS);

    logic [1:0]        strobes_s;
    logic [PAGE_W-1:0] pg_sel;
    page_st_e          pg_state;
    pg_upd_t           upd;
    logic              ram_we;
    logic [DATA_W-1:0] stored;
    logic              oe_q;

    pg_strobe_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({mem_rd_n, mem_wr_n}),
        .d_sync  (strobes_s)
    );

    pg_state_table u_tbl (
        .clk      (clk),
        .rst      (rst),
        .rd_page  (pg_sel),
        .rd_state (pg_state),
        .upd      (upd)
    );

    pg_store_ram #(.OFS_W(OFS_W)) u_ram (
        .clk   (clk),
        .addr  (bus_addr),
        .we    (ram_we),
        .wdata (bus_data_in),
        .rdata (stored)
    );

    pg_snoop_ctl #(.HOLD_CYC(HOLD_CYC)) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .rd_s_n      (strobes_s[1]),
        .wr_s_n      (strobes_s[0]),
        .bus_addr    (bus_addr),
        .bus_data_in (bus_data_in),
        .stored      (stored),
        .pg_state    (pg_state),
        .pg_sel      (pg_sel),
        .upd         (upd),
        .ram_we      (ram_we),
        .oe_q        (oe_q),
        .ready_q     (ready_pull)
    );

    // Raw read strobe gates the driver so release needs no clock edge.
    assign data_oe_n    = !(oe_q && !mem_rd_n);
    assign bus_data_out = stored;

    assert_release_on_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        mem_rd_n |-> data_oe_n);

    assert_upper_region_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(!is_conv(bus_addr)) && !is_conv(bus_addr) && $stable(bus_addr)
         && $past(strobes_s == 2'b11, 3)) |-> (data_oe_n && !ready_pull));
endmodule

// File: tb/pg_snoop_responder_tb_top.sv
module pg_snoop_responder_tb_top;

    localparam int HOLD = 80;
    localparam int K_SILENT = 0, K_SERVE = 1, K_HOST = 2, K_ABSENT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] bus_addr = '0;
    logic [7:0]  bus_data_in = 8'hFF;
    logic        mem_rd_n = 1'b1;
    logic        mem_wr_n = 1'b1;
    logic [7:0]  bus_data_out;
    logic        data_oe_n;
    logic        ready_pull;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pg_snoop_responder dut_i (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (bus_addr),
        .bus_data_in  (bus_data_in),
        .mem_rd_n     (mem_rd_n),
        .mem_wr_n     (mem_wr_n),
        .bus_data_out (bus_data_out),
        .data_oe_n    (data_oe_n),
        .ready_pull   (ready_pull)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_write(input logic [19:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_data_in = d; mem_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        mem_wr_n = 1'b1;
        repeat (4) @(negedge clk);
        bus_data_in = 8'hFF;
    endtask

    // One read cycle; host leaves hbyte on the data lines the whole time.
    task automatic do_read(input logic [19:0] a, input logic [7:0] hbyte,
                           input int kind, input logic [7:0] exp_b, input string req);
        int rcnt = 0;
        int first_oe = -1;
        int got = 0;
        bit overlap = 0;
        int exp_oe;
        int exp_r;
        @(negedge clk);
        bus_addr = a; bus_data_in = hbyte; mem_rd_n = 1'b0;
        for (int k = 1; k <= HOLD + 20; k++) begin
            @(negedge clk);
            if (ready_pull) rcnt++;
            if (ready_pull && !data_oe_n) overlap = 1;
            if (!data_oe_n && first_oe < 0) begin
                first_oe = k;
                got = int'(bus_data_out);
            end
        end
        exp_r  = (kind == K_HOST || kind == K_ABSENT) ? HOLD : 0;
        exp_oe = (kind == K_SERVE) ? 4 : (kind == K_ABSENT) ? 4 + HOLD + 1 : -1;
        chk(rcnt == exp_r, req, "wait cycles", rcnt, exp_r);
        chk(first_oe == exp_oe, req, "drive edge", first_oe, exp_oe);
        if (exp_oe > 0) chk(got == int'(exp_b), req, "driven byte", got, int'(exp_b));
        chk(!overlap, "R3", "drive during hold", int'(overlap), 0);
        mem_rd_n = 1'b1;
        #1;
        chk(data_oe_n == 1'b1, "R8", "driver off after strobe", int'(data_oe_n), 1);
        bus_data_in = 8'hFF;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk(data_oe_n == 1'b1, "R2", "oe_n after reset", int'(data_oe_n), 1);
        chk(ready_pull == 1'b0, "R2", "ready after reset", int'(ready_pull), 0);
    endtask

    task automatic t_absent_page();
        do_write(20'h10020, 8'h3C);
        do_read(20'h10020, 8'hFF, K_ABSENT, 8'h3C, "R5");
        do_read(20'h10020, 8'hFF, K_SERVE, 8'h3C, "R6");
    endtask

    task automatic t_write_update();
        do_write(20'h10020, 8'h5A);
        do_read(20'h10020, 8'hFF, K_SERVE, 8'h5A, "R7");
    endtask

    task automatic t_host_page();
        do_write(20'h20004, 8'h77);
        do_read(20'h20004, 8'h77, K_HOST, 8'h00, "R4");
        do_read(20'h20004, 8'h77, K_SILENT, 8'h00, "R4");
        do_read(20'h20004, 8'h12, K_SILENT, 8'h00, "R11");
    endtask

    task automatic t_independent_pages();
        do_write(20'h30011, 8'h12);
        do_read(20'h30011, 8'hFF, K_ABSENT, 8'h12, "R10");
        do_write(20'h9FFFF, 8'hA5);
        do_read(20'h9FFFF, 8'hFF, K_ABSENT, 8'hA5, "R10");
        do_read(20'h20004, 8'h77, K_SILENT, 8'h00, "R10");
    endtask

    task automatic t_upper_region();
        do_write(20'hA0000, 8'h44);
        do_read(20'hA0000, 8'hFF, K_SILENT, 8'h00, "R1");
        do_read(20'hC0010, 8'hFF, K_SILENT, 8'h00, "R1");
    endtask

    task automatic t_hold_strobe();
        bit saw_ready = 0;
        do_write(20'h40001, 8'h01);
        @(negedge clk);
        bus_addr = 20'h10020; bus_data_in = 8'hFF; mem_rd_n = 1'b0;
        repeat (8) @(negedge clk);
        chk(data_oe_n == 1'b0, "R9", "first read driven", int'(data_oe_n), 0);
        bus_addr = 20'h40001;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (ready_pull) saw_ready = 1;
        end
        chk(!saw_ready, "R9", "new cycle while strobe held", int'(saw_ready), 0);
        mem_rd_n = 1'b1;
        repeat (4) @(negedge clk);
        do_read(20'h40001, 8'hFF, K_ABSENT, 8'h01, "R9");
    endtask

    task automatic t_reset_relearn();
        do_reset();
        t_reset_state();
        do_read(20'h10020, 8'hFF, K_ABSENT, 8'h5A, "R2");
        do_read(20'h20004, 8'hFF, K_ABSENT, 8'h77, "R3");
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        t_reset_state();
        t_absent_page();
        t_write_update();
        t_host_page();
        t_independent_pages();
        t_upper_region();
        t_hold_strobe();
        t_reset_relearn();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule